// File: doc/BRIEF.md
# Debug watchpoint chain and counter unit

This block decides, once per cycle, whether a CPU access should stop execution and hand control to the debugger. It takes raw compare hits from the address and data comparators, which are outside this block. It also takes the debug mode settings: a per-watchpoint chain mode, a counter assignment, a break-generate mask, two counter enables, a single-step bit and a debugger-disable bit. From these it works out the match of each of eleven watchpoints. Each watchpoint can be combined with the match of the one below it by AND or by OR, so several comparators can act together as one condition.

Two 16-bit event counters count watchpoint matches. Each counter compares its count with its own match value, and the result of that compare is fed back in as the own term of watchpoints 8 and 9. This lets a break fire after N occurrences of an event. Watchpoint 10 is reserved for an external source and is tied inactive.

The break request is combinational for the access that is presented. Counter updates and the stall flag are registered.

Top module: `dwu_top`

## Requirements
- R1: While `dbgEnable` is 0 or `inReset` is 1, `brkReq` is 0, `wpMatch` is all zero and no counter increments.
- R2: An access with `accValid`=1, `accFetch`=1 and `stepMode`=1 raises `brkReq` in the same cycle, whatever the watchpoint settings. That access does not increment either counter.
- R3: Watchpoints are evaluated only when `accValid` is 1 and at least one bit of `brkMask` or `cntSel` is set. Otherwise `wpMatch` is zero, there is no watchpoint break and no increment.
- R4: The chain mode of watchpoint i is `chainMode[2i+1:2i]`. Value 0 gives the own term. Value 1 gives the own term AND the previous match. Value 2 gives the own term OR the previous match. Value 3 gives no match. For watchpoints 0 to 7 the own term is `rawHit[i]` and the previous match is that of watchpoint i-1. For watchpoint 0 the previous term is `rawHit[0]` itself.
- R5: The own term of watchpoint 8 is `count0 == matchVal0`, and it chains to watchpoint 7. The own term of watchpoint 9 is `count1 == matchVal1`, and it chains to watchpoint 8. Watchpoint 10 never matches. `rawHit[10:8]` has no effect.
- R6: Each matching watchpoint i counts once per cycle. It counts into counter 1 when `cntSel[i]`=1 and into counter 0 when `cntSel[i]`=0. A counter whose `cntEn` bit is set grows at the clock edge by the number of matching watchpoints assigned to it, modulo 2^16.
- R7: `brkReq` is 1 when any bit of `wpMatch & brkMask` is set.
- R8: `stallOut` becomes `stallReq & ~dbgOff` one clock after the inputs are presented.
- R9: `cntWr[k]`=1 loads `cntWrData` into counter k at the clock edge. The load takes priority over an increment in the same cycle.
- R10: After reset, `count0`, `count1` and `stallOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgEnable | input | 1 | Global debug enable |
| inReset | input | 1 | CPU reset in progress |
| accValid | input | 1 | An access is presented this cycle |
| accFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| stepMode | input | 1 | Single-step enable |
| dbgOff | input | 1 | Debugger disable, masks the stall |
| stallReq | input | 1 | Requested stall state |
| rawHit | input | 11 | Comparator hit per watchpoint (bits 10:8 unused) |
| chainMode | input | 22 | 2-bit chain mode per watchpoint |
| cntSel | input | 11 | Counter assignment per watchpoint |
| cntEn | input | 2 | Enable for counter 1 and counter 0 |
| brkMask | input | 11 | Break-generate bit per watchpoint |
| cntWr | input | 2 | Count load strobe per counter |
| cntWrData | input | 16 | Count load value |
| matchVal0 | input | 16 | Match value of counter 0 |
| matchVal1 | input | 16 | Match value of counter 1 |
| brkReq | output | 1 | Break request for the current access |
| stallOut | output | 1 | Registered stall flag |
| wpMatch | output | 11 | Per-watchpoint match vector this cycle |
| count0 | output | 16 | Counter 0 value |
| count1 | output | 16 | Counter 1 value |

## Verification
A count load and a match-driven increment of the same counter can fall in the same cycle. So can a counter's compare result and a chained break that depends on it. The bench provokes both with directed cycles that strobe `cntWr` while assigned watchpoints match. It also places `matchVal` next to the running count so that watchpoints 8 and 9 turn on in the middle of random traffic. A reference model judges each case. In that model the load wins, and the compare uses the count held before the edge.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  typedef struct packed {
    logic evalEn;
    logic stepBrk;
  } dwuStrobes_t;
endpackage

// File: rtl/dwu_ctrl.sv
module dwu_ctrl
  import dwu_pkg::*;
#(
  parameter int NUM_WP = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEnable,
  input  logic              inReset,
  input  logic              accValid,
  input  logic              accFetch,
  input  logic              stepMode,
  input  logic              dbgOff,
  input  logic              stallReq,
  input  logic [NUM_WP-1:0] cntSel,
  input  logic [NUM_WP-1:0] brkMask,
  output dwuStrobes_t       strobes,
  output logic              stallOut
);
  logic debugLive;
  logic stepFetch;
  logic anyArmed;

  // The debug unit is live only when enabled and the CPU is out of reset.
  assign debugLive = dbgEnable && !inReset;
  assign stepFetch = debugLive && accValid && accFetch && stepMode;
  assign anyArmed  = (|brkMask) || (|cntSel);

  always_comb begin
    strobes.stepBrk = stepFetch;
    strobes.evalEn  = debugLive && accValid && !stepFetch && anyArmed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallOut <= 1'b0;
    else       stallOut <= stallReq && !dbgOff;
  end
endmodule

// File: rtl/dwu_datapath.sv
module dwu_datapath
  import dwu_pkg::*;
#(
  parameter int NUM_WP = 11,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dwuStrobes_t         strobes,
  input  logic [NUM_WP-1:0]   rawHit,
  input  logic [2*NUM_WP-1:0] chainMode,
  input  logic [NUM_WP-1:0]   cntSel,
  input  logic [1:0]          cntEn,
  input  logic [NUM_WP-1:0]   brkMask,
  input  logic [1:0]          cntWr,
  input  logic [CNT_W-1:0]    cntWrData,
  input  logic [CNT_W-1:0]    matchVal0,
  input  logic [CNT_W-1:0]    matchVal1,
  output logic                brkReq,
  output logic [NUM_WP-1:0]   wpMatch,
  output logic [CNT_W-1:0]    count0,
  output logic [CNT_W-1:0]    count1
);
  localparam int WP_CNT0 = NUM_WP - 3;
  localparam int WP_CNT1 = NUM_WP - 2;
  localparam int WP_EXT  = NUM_WP - 1;
  localparam int SUM_W   = $clog2(NUM_WP + 1);

  logic [CNT_W-1:0]  countQ [2];
  logic [CNT_W-1:0]  limit  [2];
  logic [NUM_WP-1:0] ownTerm;
  logic [NUM_WP-1:0] prevTerm;
  logic [NUM_WP-1:0] chainOut;
  logic [SUM_W-1:0]  incAmt [2];

  assign limit[0] = matchVal0;
  assign limit[1] = matchVal1;

  function automatic logic [SUM_W-1:0] onesOf(input logic [NUM_WP-1:0] v);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < NUM_WP; b++) acc = acc + SUM_W'(v[b]);
    return acc;
  endfunction

  for (genvar gi = 0; gi < NUM_WP; gi++) begin : g_wp
    if (gi == WP_CNT0) begin : g_own_c0
      assign ownTerm[gi] = (countQ[0] == limit[0]);
    end else if (gi == WP_CNT1) begin : g_own_c1
      assign ownTerm[gi] = (countQ[1] == limit[1]);
    end else if (gi == WP_EXT) begin : g_own_ext
      assign ownTerm[gi] = rawHit[gi] & 1'b0;
    end else begin : g_own_hit
      assign ownTerm[gi] = rawHit[gi];
    end

    if (gi == 0) begin : g_prev_first
      assign prevTerm[gi] = rawHit[0];
    end else begin : g_prev_chain
      assign prevTerm[gi] = chainOut[gi-1];
    end

    if (gi == WP_EXT) begin : g_tied
      assign chainOut[gi] = 1'b0;
    end else begin : g_comb
      always_comb begin
        unique case (chainMode[2*gi +: 2])
          2'd0:    chainOut[gi] = ownTerm[gi];
          2'd1:    chainOut[gi] = ownTerm[gi] && prevTerm[gi];
          2'd2:    chainOut[gi] = ownTerm[gi] || prevTerm[gi];
          default: chainOut[gi] = 1'b0;
        endcase
      end
    end
  end

  assign wpMatch = chainOut & {NUM_WP{strobes.evalEn}};
  assign brkReq  = strobes.stepBrk || (|(wpMatch & brkMask));

  assign incAmt[0] = onesOf(wpMatch & ~cntSel);
  assign incAmt[1] = onesOf(wpMatch & cntSel);

  for (genvar gk = 0; gk < 2; gk++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          countQ[gk] <= '0;
      else if (cntWr[gk]) countQ[gk] <= cntWrData;
      else if (cntEn[gk]) countQ[gk] <= countQ[gk] + CNT_W'(incAmt[gk]);
    end
  end

  assign count0 = countQ[0];
  assign count1 = countQ[1];
endmodule

// File: rtl/dwu_top.sv
module dwu_top
  import dwu_pkg::*;
#(
  parameter int NUM_WP = 11,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dbgEnable,
  input  logic                inReset,
  input  logic                accValid,
  input  logic                accFetch,
  input  logic                stepMode,
  input  logic                dbgOff,
  input  logic                stallReq,
  input  logic [NUM_WP-1:0]   rawHit,
  input  logic [2*NUM_WP-1:0] chainMode,
  input  logic [NUM_WP-1:0]   cntSel,
  input  logic [1:0]          cntEn,
  input  logic [NUM_WP-1:0]   brkMask,
  input  logic [1:0]          cntWr,
  input  logic [CNT_W-1:0]    cntWrData,
  input  logic [CNT_W-1:0]    matchVal0,
  input  logic [CNT_W-1:0]    matchVal1,
  output logic                brkReq,
  output logic                stallOut,
  output logic [NUM_WP-1:0]   wpMatch,
  output logic [CNT_W-1:0]    count0,
  output logic [CNT_W-1:0]    count1
);
  dwuStrobes_t strobes;

  dwu_ctrl #(.NUM_WP(NUM_WP)) u_ctrl (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .inReset(inReset),
    .accValid(accValid), .accFetch(accFetch), .stepMode(stepMode),
    .dbgOff(dbgOff), .stallReq(stallReq), .cntSel(cntSel),
    .brkMask(brkMask), .strobes(strobes), .stallOut(stallOut)
  );

  dwu_datapath #(.NUM_WP(NUM_WP), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rawHit(rawHit),
    .chainMode(chainMode), .cntSel(cntSel), .cntEn(cntEn),
    .brkMask(brkMask), .cntWr(cntWr), .cntWrData(cntWrData),
    .matchVal0(matchVal0), .matchVal1(matchVal1), .brkReq(brkReq),
    .wpMatch(wpMatch), .count0(count0), .count1(count1)
  );
endmodule

// File: rtl/dwu_checker.sv
module dwu_checker #(
  parameter int NUM_WP = 11,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              dbgEnable,
  input logic              inReset,
  input logic              accValid,
  input logic              accFetch,
  input logic              stepMode,
  input logic              dbgOff,
  input logic              stallReq,
  input logic [NUM_WP-1:0] cntSel,
  input logic [NUM_WP-1:0] brkMask,
  input logic [1:0]        cntEn,
  input logic [1:0]        cntWr,
  input logic [CNT_W-1:0]  cntWrData,
  input logic              brkReq,
  input logic              stallOut,
  input logic [NUM_WP-1:0] wpMatch,
  input logic [CNT_W-1:0]  count0,
  input logic [CNT_W-1:0]  count1
);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgEnable || inReset) |-> (!brkReq && wpMatch == '0));

  p_step_brk_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEnable && !inReset && accValid && accFetch && stepMode) |-> brkReq);

  p_unarmed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (brkMask == '0 && cntSel == '0) |-> (wpMatch == '0));

  p_ext_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wpMatch[NUM_WP-1]);

  p_break_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(wpMatch & brkMask)) |-> brkReq);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (stallOut == $past(stallReq && !dbgOff)));

  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    cntWr[0] |=> (count0 == $past(cntWrData)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr[1] && !cntEn[1]) |=> $stable(count1));
endmodule

bind dwu_top dwu_checker #(.NUM_WP(NUM_WP), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_dwu_top.sv
`timescale 1ns/1ps
module test_dwu_top;
  localparam int NW = 11;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgEnable, inReset, accValid, accFetch, stepMode, dbgOff, stallReq;
  logic [NW-1:0]   rawHit, cntSel, brkMask;
  logic [2*NW-1:0] chainMode;
  logic [1:0]      cntEn, cntWr;
  logic [CW-1:0]   cntWrData, matchVal0, matchVal1;
  logic            brkReq, stallOut;
  logic [NW-1:0]   wpMatch;
  logic [CW-1:0]   count0, count1;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [CW-1:0] mc0, mc1;
  logic          mStall;

  always #2 clk = ~clk;

  dwu_top i_dwu_top (.*);

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit evalOn();
    return dbgEnable && !inReset && accValid && !(stepMode && accFetch)
           && ((brkMask != 0) || (cntSel != 0));
  endfunction

  function automatic logic [NW-1:0] refMatch();
    logic [NW-1:0] m = '0;
    if (!evalOn()) return '0;
    for (int i = 0; i < NW; i++) begin
      logic own, prv;
      if (i == 8)       own = (mc0 == matchVal0);
      else if (i == 9)  own = (mc1 == matchVal1);
      else if (i == 10) own = 1'b0;
      else              own = rawHit[i];
      prv = (i == 0) ? rawHit[0] : m[i-1];
      case (chainMode[2*i +: 2])
        2'd0: m[i] = own;
        2'd1: m[i] = own & prv;
        2'd2: m[i] = own | prv;
        default: m[i] = 1'b0;
      endcase
      if (i == 10) m[i] = 1'b0;
    end
    return m;
  endfunction

  // Inputs are set at the falling edge; outputs checked 1 ns later; model steps at the rising edge.
  task automatic cycle(string tag);
    logic [NW-1:0] m;
    logic expBrk;
    int n0, n1;
    #1;
    m = refMatch();
    expBrk = (dbgEnable && !inReset && accValid && accFetch && stepMode) || ((m & brkMask) != 0);
    check(tag, "wpMatch", 32'(wpMatch), 32'(m));
    check(tag, "brkReq", 32'(brkReq), 32'(expBrk));
    check(tag, "count0", 32'(count0), 32'(mc0));
    check(tag, "count1", 32'(count1), 32'(mc1));
    check(tag, "stallOut", 32'(stallOut), 32'(mStall));
    n0 = 0; n1 = 0;
    for (int i = 0; i < NW; i++) if (m[i]) begin
      if (cntSel[i]) n1++; else n0++;
    end
    @(posedge clk);
    if (cntWr[0]) mc0 = cntWrData; else if (cntEn[0]) mc0 = mc0 + CW'(n0);
    if (cntWr[1]) mc1 = cntWrData; else if (cntEn[1]) mc1 = mc1 + CW'(n1);
    mStall = stallReq && !dbgOff;
    @(negedge clk);
  endtask

  task automatic idle();
    dbgEnable = 1; inReset = 0; accValid = 1; accFetch = 0; stepMode = 0;
    dbgOff = 0; stallReq = 0; rawHit = '0; chainMode = '0; cntSel = '0;
    brkMask = '0; cntEn = 2'b00; cntWr = 2'b00; cntWrData = '0;
    matchVal0 = 16'hffff; matchVal1 = 16'hffff;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    mc0 = '0; mc1 = '0; mStall = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    cycle("R10");

    // R1: hits present but debug disabled, then in reset
    brkMask = '1; cntEn = 2'b11; rawHit = 11'h0ff; dbgEnable = 0;
    cycle("R1");
    dbgEnable = 1; inReset = 1; stepMode = 1; accFetch = 1;
    cycle("R1");
    inReset = 0; stepMode = 0; accFetch = 0;

    // R3: nothing armed, then no access
    brkMask = '0; cntSel = '0;
    cycle("R3");
    brkMask = '1; accValid = 0;
    cycle("R3");
    accValid = 1;

    // R2: single-step fetch breaks, no counting even with hits
    brkMask = '0; cntSel = 11'h001; stepMode = 1; accFetch = 1; rawHit = '0;
    cycle("R2");
    rawHit = 11'h0ff; cntSel = 11'h0f0;
    cycle("R2");
    stepMode = 0; accFetch = 0;

    // R4: AND/OR chain and reserved mode
    rawHit = 11'h005; brkMask = 11'h004; cntEn = 2'b00;
    chainMode = {16'h0, 2'd2, 2'd1, 2'd0}; // wp2 OR, wp1 AND, wp0 own
    cycle("R4");
    chainMode = {16'h0, 2'd3, 2'd1, 2'd0};
    cycle("R4");

    // R9: load beats increment in same cycle; R6 increments count
    chainMode = '0; rawHit = 11'h0ff; cntSel = 11'h00f; cntEn = 2'b11;
    cntWr = 2'b01; cntWrData = 16'h1234;
    cycle("R9");
    cntWr = 2'b00;
    cycle("R6");
    // R6: wrap at 16 bits
    cntWr = 2'b10; cntWrData = 16'hfffe;
    cycle("R9");
    cntWr = 2'b00;
    cycle("R6");

    // R5: counter compare feeds watchpoints 8 and 9; rawHit[10:8] ignored
    rawHit = 11'h700; cntEn = 2'b00; brkMask = 11'h300;
    matchVal0 = mc0; matchVal1 = mc1 + 1;
    cycle("R5");
    matchVal1 = mc1;
    chainMode = {2'd2, 2'd2, 2'd1, 16'h0}; // wp10 OR, wp9 OR, wp8 AND wp7
    rawHit = 11'h080;
    cycle("R5");

    // R8: stall gating
    stallReq = 1; dbgOff = 1;
    cycle("R8");
    dbgOff = 0;
    cycle("R8");
    cycle("R8");

    // Random traffic
    void'($urandom(32'h5eed));
    for (int k = 0; k < 3000; k++) begin
      dbgEnable = ($urandom % 16) != 0;
      inReset   = ($urandom % 20) == 0;
      accValid  = ($urandom % 8) != 0;
      accFetch  = $urandom % 2;
      stepMode  = ($urandom % 6) == 0;
      dbgOff    = $urandom % 2;
      stallReq  = $urandom % 2;
      rawHit    = NW'($urandom);
      chainMode = (2*NW)'($urandom);
      cntSel    = ($urandom % 5 == 0) ? '0 : NW'($urandom);
      brkMask   = ($urandom % 5 == 0) ? '0 : NW'($urandom);
      cntEn     = 2'($urandom);
      cntWr     = ($urandom % 12 == 0) ? 2'($urandom) : 2'b00;
      cntWrData = ($urandom % 4 == 0) ? 16'hfff8 : 16'($urandom % 8);
      matchVal0 = mc0 + 16'($urandom % 3);
      matchVal1 = mc1 + 16'($urandom % 3);
      cycle("R4 R6 R7 R8");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule